// File: doc/BRIEF.md
# Lock-Gated Reset Sequencer for Synthesized Clock Domains

This block brings a group of clock domains out of reset when their clocks come from an on-chip frequency synthesizer. The synthesizer has a reset input and a lock flag, and it produces no output clocks while it is held in reset. The block's own control logic runs on an independent free-running clock. It pulses the synthesizer reset for a fixed minimum length, then releases it and waits for lock. Only after lock has been seen does it let each derived domain leave reset.

Every derived domain has its own small release stage, clocked by that domain's clock. The stage asserts the domain reset asynchronously whenever the raw system reset is active, so the assertion does not need a running clock. The stage releases the reset synchronously to a rising edge of the domain clock. The delay after lock is set separately for each domain. If lock drops while the system is running, the control logic goes back to waiting for lock and every domain reset is asserted again. The synthesizer is not reset again in that case.

Top module: `pll_rst_seq`

## Requirements
- R1: While `sys_rst` (active high) is asserted, `synth_rst` is high. It rises as soon as `sys_rst` rises, without waiting for any clock edge.
- R2: After `sys_rst` is released, `synth_rst` stays high for at least `HOLD_CYCLES` and at most `HOLD_CYCLES`+4 rising edges of `ctl_clk`. The count starts at the first edge after the release.
- R3: `synth_rst` falls without waiting for `lock_in`. It is not asserted again when lock is lost; only `sys_rst` asserts it again.
- R4: No bit of `dom_rst` goes low while `lock_in` is low.
- R5: All bits of `dom_rst` rise as soon as `sys_rst` rises, even when the domain clocks are stopped. They stay high for as long as those clocks remain stopped.
- R6: For domain i, let the delay be D = `DOM_DELAYS[i*DLY_W +: DLY_W]`. Bit i of `dom_rst` falls right after a rising edge of `dom_clk[i]`. Counting inclusively from the first edge of that clock at which `lock_in` is high, that edge is number D+3 or later, and number D+12 or earlier.
- R7: If `lock_in` goes low for at least six `ctl_clk` cycles while the domains are running, every bit of `dom_rst` is high again by the end of that time. When lock returns, each domain is released again as R6 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Free-running control clock that does not come from the synthesizer |
| sys_rst | input | 1 | Raw system reset, active high, asynchronous |
| lock_in | input | 1 | Lock flag from the synthesizer, asynchronous |
| synth_rst | output | 1 | Reset to the synthesizer, active high |
| dom_clk | input | NUM_DOM | One derived clock per domain |
| dom_rst | output | NUM_DOM | Synchronous reset per domain, active high |

## Verification
The bench builds the block with two domains, `HOLD_CYCLES` = 6, and post-lock delays of 3 and 8. The two domain clocks have periods of 8 ns and 14 ns, neither of them locked to the 10 ns control clock. The short hold keeps the check on the synthesizer pulse length tight. The two different delays, each counted in its own clock, show that each domain releases by its own count. The bench's clock model stops both derived clocks whenever `synth_rst` is high. This exposes any domain reset that relies on a clock edge to assert. Lock arrives after a random delay and is also dropped while the system is running, so the release bounds are checked both at start-up and after a loss of lock.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    // Control sequence run on the independent clock
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // synthesizer held in reset
        ST_WAIT = 2'd1,   // reset released, waiting for lock
        ST_RUN  = 2'd2    // locked, domains may leave reset
    } ctl_state_e;

endpackage

// File: rtl/rstseq_sync2.sv
`timescale 1ns/1ps
module rstseq_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);

    logic [1:0] sh_d;
    logic [1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[0], d};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            sh_q <= {2{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[1];

endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic ctl_clk,
    input  logic sys_rst,
    input  logic lock_in,
    output logic synth_rst,
    output logic run
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [CW-1:0] cnt;
        logic          srst;
        logic          run;
    } ctl_regs_t;

    logic rst_sync;
    logic lock_s;
    ctl_regs_t r_d;
    ctl_regs_t r_q;

    // Asynchronous assertion, release aligned to the control clock
    rstseq_sync2 #(.RST_VAL(1'b1)) u_rst_sync (
        .clk  (ctl_clk),
        .arst (sys_rst),
        .d    (1'b0),
        .q    (rst_sync)
    );

    rstseq_sync2 #(.RST_VAL(1'b0)) u_lock_sync (
        .clk  (ctl_clk),
        .arst (sys_rst),
        .d    (lock_in),
        .q    (lock_s)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_HOLD: begin
                r_d.srst = 1'b1;
                if (r_q.cnt == CW'(HOLD_CYCLES - 1)) begin
                    r_d.st   = ST_WAIT;
                    r_d.srst = 1'b0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                r_d.srst = 1'b0;
                if (lock_s) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.srst = 1'b0;
                if (!lock_s) begin
                    r_d.st = ST_WAIT;
                end
            end
            default: begin
                r_d.st   = ST_HOLD;
                r_d.cnt  = '0;
                r_d.srst = 1'b1;
            end
        endcase
        r_d.run = (r_d.st == ST_RUN);
    end

    always_ff @(posedge ctl_clk or posedge rst_sync) begin
        if (rst_sync) begin
            r_q <= '{st: ST_HOLD, cnt: '0, srst: 1'b1, run: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign synth_rst = r_q.srst;
    assign run       = r_q.run;

    // Checker-only count of cycles the synthesizer reset was seen high
    logic [15:0] hold_seen_q;
    always_ff @(posedge ctl_clk or posedge rst_sync) begin
        if (rst_sync) begin
            hold_seen_q <= '0;
        end else if (r_q.srst && hold_seen_q != 16'hFFFF) begin
            hold_seen_q <= hold_seen_q + 1'b1;
        end
    end

    a_r2_hold_min: assert property (@(posedge ctl_clk) disable iff (rst_sync)
        $fell(synth_rst) |-> (hold_seen_q >= 16'(HOLD_CYCLES)));

    a_r3_no_repulse: assert property (@(posedge ctl_clk) disable iff (rst_sync)
        (r_q.st != ST_HOLD) |=> !synth_rst);

    a_r3_run_needs_lock: assert property (@(posedge ctl_clk) disable iff (rst_sync)
        $rose(run) |-> $past(lock_s));

    a_r7_loss_to_wait: assert property (@(posedge ctl_clk) disable iff (rst_sync)
        (r_q.st == ST_RUN && !lock_s) |=> (r_q.st == ST_WAIT && !run));

endmodule

// File: rtl/rstseq_dom.sv
`timescale 1ns/1ps
module rstseq_dom #(
    parameter int DELAY = 8
) (
    input  logic dom_clk,
    input  logic arst,
    input  logic run_in,
    input  logic lock_in,
    output logic dom_rst
);

    localparam int CW = $clog2(DELAY + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } dom_regs_t;

    logic run_s;
    logic lock_s;
    logic ok;
    dom_regs_t r_d;
    dom_regs_t r_q;

    rstseq_sync2 #(.RST_VAL(1'b0)) u_run_sync (
        .clk  (dom_clk),
        .arst (arst),
        .d    (run_in),
        .q    (run_s)
    );

    rstseq_sync2 #(.RST_VAL(1'b0)) u_lock_sync (
        .clk  (dom_clk),
        .arst (arst),
        .d    (lock_in),
        .q    (lock_s)
    );

    assign ok = run_s & lock_s;

    always_comb begin
        r_d = r_q;
        if (!ok) begin
            r_d.cnt = '0;
            r_d.rst = 1'b1;
        end else if (r_q.cnt == CW'(DELAY)) begin
            r_d.rst = 1'b0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
            r_d.rst = 1'b1;
        end
    end

    // Assertion needs no running clock; release follows the clock edge
    always_ff @(posedge dom_clk or posedge arst) begin
        if (arst) begin
            r_q <= '{cnt: '0, rst: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign dom_rst = r_q.rst;

    a_r6_release_after_count: assert property (@(posedge dom_clk) disable iff (arst)
        $fell(dom_rst) |-> ($past(ok) && $past(r_q.cnt) == CW'(DELAY)));

    a_r4_no_release_unlocked: assert property (@(posedge dom_clk) disable iff (arst)
        !lock_s |=> dom_rst);

    a_r7_drop_reasserts: assert property (@(posedge dom_clk) disable iff (arst)
        !ok |=> dom_rst);

endmodule

// File: rtl/pll_rst_seq.sv
`timescale 1ns/1ps
module pll_rst_seq #(
    parameter int                       NUM_DOM     = 2,
    parameter int                       HOLD_CYCLES = 16,
    parameter int                       DLY_W       = 8,
    parameter logic [NUM_DOM*DLY_W-1:0] DOM_DELAYS  = {NUM_DOM{DLY_W'(8)}}
) (
    input  logic               ctl_clk,
    input  logic               sys_rst,
    input  logic               lock_in,
    output logic               synth_rst,
    input  logic [NUM_DOM-1:0] dom_clk,
    output logic [NUM_DOM-1:0] dom_rst
);

    logic run;

    rstseq_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .ctl_clk   (ctl_clk),
        .sys_rst   (sys_rst),
        .lock_in   (lock_in),
        .synth_rst (synth_rst),
        .run       (run)
    );

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        localparam int DLY_I = int'(DOM_DELAYS[i*DLY_W +: DLY_W]);
        rstseq_dom #(.DELAY(DLY_I)) u_dom (
            .dom_clk (dom_clk[i]),
            .arst    (sys_rst),
            .run_in  (run),
            .lock_in (lock_in),
            .dom_rst (dom_rst[i])
        );
    end

    a_r1_synth_in_reset: assert property (@(posedge ctl_clk)
        sys_rst |-> synth_rst);

    a_r5_domains_in_reset: assert property (@(posedge ctl_clk)
        sys_rst |-> (&dom_rst));

endmodule

// File: tb/sim_pll_rst_seq.sv
`timescale 1ns/1ps
module sim_pll_rst_seq;

    localparam int HOLD = 6;
    localparam int D0   = 3;
    localparam int D1   = 8;

    logic       clk = 1'b0;
    logic       sys_rst = 1'b0;
    logic       lock = 1'b0;
    logic       synth_rst;
    logic       dclk0 = 1'b0;
    logic       dclk1 = 1'b0;
    logic [1:0] dclk;
    logic [1:0] dom_rst;

    int n_chk = 0;
    int n_bad = 0;
    int e0 = 0, e1 = 0;     // edges with lock high, per domain
    int t0 = 0, t1 = 0;     // all edges, per domain
    bit done = 0;

    assign dclk = {dclk1, dclk0};

    pll_rst_seq #(
        .NUM_DOM     (2),
        .HOLD_CYCLES (HOLD),
        .DLY_W       (8),
        .DOM_DELAYS  ({8'(D1), 8'(D0)})
    ) u0 (
        .ctl_clk   (clk),
        .sys_rst   (sys_rst),
        .lock_in   (lock),
        .synth_rst (synth_rst),
        .dom_clk   (dclk),
        .dom_rst   (dom_rst)
    );

    always #5 clk = ~clk;

    // Synthesizer model: derived clocks stop while its reset is high
    always begin
        if (synth_rst !== 1'b0) begin
            dclk0 = 1'b0;
            @(negedge synth_rst);
        end else begin
            #4 dclk0 = ~dclk0;
        end
    end
    always begin
        if (synth_rst !== 1'b0) begin
            dclk1 = 1'b0;
            @(negedge synth_rst);
        end else begin
            #7 dclk1 = ~dclk1;
        end
    end
    always @(posedge synth_rst) lock = 1'b0;

    always @(posedge dclk0) begin t0++; if (lock) e0++; else e0 = 0; end
    always @(posedge dclk1) begin t1++; if (lock) e1++; else e1 = 0; end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R6 / R4: release edge counted from the first edge with lock high
    always @(negedge dom_rst[0]) begin
        #1;
        check(e0 >= D0 + 3 && e0 <= D0 + 12, "R6", "dom0 release edge", e0, D0 + 3);
    end
    always @(negedge dom_rst[1]) begin
        #1;
        check(e1 >= D1 + 3 && e1 <= D1 + 12, "R6", "dom1 release edge", e1, D1 + 3);
    end

    task automatic wait_release();
        for (int k = 0; k < 80 && dom_rst != 2'b00; k++) @(negedge clk);
        #2;
        check(dom_rst == 2'b00, "R6", "both domains released", dom_rst, 0);
    endtask

    task automatic t_power_on();
        #1 sys_rst = 1'b1;
        #2;
        check(synth_rst == 1'b1, "R1", "synth reset at reset", synth_rst, 1);
        check(dom_rst == 2'b11, "R5", "domain resets at reset", dom_rst, 3);
        repeat (5) @(negedge clk);
        check(t0 + t1 == 0, "R5", "derived clocks stopped", t0 + t1, 0);
        check(dom_rst == 2'b11, "R5", "held with clocks stopped", dom_rst, 3);
    endtask

    task automatic t_bringup(input int lock_wait);
        int n;
        int s0;
        @(negedge clk);
        sys_rst = 1'b0;
        n = 0;
        while (synth_rst && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n >= HOLD && n <= HOLD + 4, "R2", "synth reset length", n, HOLD);
        check(synth_rst == 1'b0 && lock == 1'b0, "R3", "release before lock",
              synth_rst, 0);
        s0 = t0 + t1;
        repeat (lock_wait) @(negedge clk);
        check(t0 + t1 > s0, "R3", "derived clocks run before lock", t0 + t1 - s0, 1);
        check(dom_rst == 2'b11, "R4", "held while unlocked", dom_rst, 3);
        lock = 1'b1;
        wait_release();
    endtask

    task automatic t_lock_loss();
        @(negedge clk);
        lock = 1'b0;
        repeat (6) @(negedge clk);
        check(dom_rst == 2'b11, "R7", "reasserted on lock loss", dom_rst, 3);
        check(synth_rst == 1'b0, "R3", "no synth reset on lock loss", synth_rst, 0);
        repeat (10) @(negedge clk);
        check(dom_rst == 2'b11, "R4", "held while lock low", dom_rst, 3);
        lock = 1'b1;
        wait_release();
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        #2 sys_rst = 1'b1;
        #1;
        check(dom_rst == 2'b11, "R5", "async assert in run", dom_rst, 3);
        check(synth_rst == 1'b1, "R1", "synth reset async assert", synth_rst, 1);
        repeat (8) @(negedge clk);
        check(dom_rst == 2'b11, "R5", "held during reset", dom_rst, 3);
        check(synth_rst == 1'b1, "R1", "synth held during reset", synth_rst, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        t_power_on();
        t_bringup(3 + int'($urandom_range(0, 20)));
        t_lock_loss();
        t_mid_reset();
        t_bringup(40);
        t_lock_loss();
        t_mid_reset();
        t_bringup(1 + int'($urandom_range(0, 5)));
        repeat (5) @(negedge clk);
        done = 1;
        summary();
    end

endmodule